// File: doc/BRIEF.md
# Predicated Vector Write Combiner

This block sits in front of the write port of a 512-bit vector register file. Each transfer brings a freshly computed result vector and the current contents of the destination register. The block chooses a per-lane predicate from a bank of eight 64-bit predicate registers and builds the final write value. Lanes whose predicate bit is set take the new result. Lanes whose predicate bit is clear are either cleared to zero or keep the old destination bits, as a mode flag selects.

A 3-bit selector names the predicate register. The selector value 0 never reads register 0; it stands for "unpredicated", and every lane is written. Register 0 is still an ordinary register that other logic may read and write. The lane size follows a 2-bit width code, so the same 64-bit predicate covers 64 byte lanes, 32 halfword lanes, 16 word lanes or 8 doubleword lanes. Only the low bits that have a lane are used.

Transfers enter and leave on valid/ready handshakes. A transfer is accepted when `in_valid` and `in_ready` are both high on a clock edge, and its combined vector is offered on the output from the next cycle. While `out_valid` is high and `out_ready` is low, the output is held unchanged and `in_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The selector, predicate bank, width code and mode are sampled together with the data on acceptance.

Top module: `vmask_writer`

## Requirements
- R1: When the selector is 1 to 7, the predicate is predicate register s, taken from bits [64*s+63 : 64*s] of `mreg_bank`.
- R2: When the selector is 0, every lane is treated as selected, and the output equals `result`.
- R3: With selector 0, the contents of predicate register 0 (bits [63:0] of `mreg_bank`) have no effect on the output.
- R4: In zeroing mode (`zero_mode` = 1), every lane whose predicate bit is clear is output as all zeros.
- R5: In merging mode (`zero_mode` = 0), every lane whose predicate bit is clear is output equal to the matching bits of `old_dst`.
- R6: Width code 00 selects 64 byte lanes. Predicate bit i controls vector bits [8i+7:8i].
- R7: Width code 01 selects 32 halfword lanes. Predicate bit i controls bits [16i+15:16i].
- R8: Width code 10 selects 16 word lanes. Predicate bit i controls bits [32i+31:32i].
- R9: Width code 11 selects 8 doubleword lanes. Predicate bit i controls bits [64i+63:64i].
- R10: Predicate bits at or above the lane count of the chosen width have no effect on the output.
- R11: The combined vector of an accepted transfer appears on `out_data`, with `out_valid` high, in the cycle after acceptance.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low. Otherwise `in_ready` is high.
- R13: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Block can take an input transfer |
| result | input | 512 | Newly computed vector |
| old_dst | input | 512 | Current destination contents |
| msel | input | 3 | Predicate register selector; 0 means unpredicated |
| mreg_bank | input | 512 | Eight 64-bit predicate registers; register k at bits [64k+63:64k] |
| ewidth | input | 2 | Lane width code: 00 byte, 01 halfword, 10 word, 11 doubleword |
| zero_mode | input | 1 | 1 clears unselected lanes, 0 keeps old contents |
| out_valid | output | 1 | Write strobe; combined vector present |
| out_ready | input | 1 | Register file takes the combined vector |
| out_data | output | 512 | Combined write value |

## Verification
The assertions assume the upstream source keeps `result`, `old_dst`, `msel`, `mreg_bank`, `ewidth` and `zero_mode` settled through the sampling edge. They also assume these inputs are known values whenever `in_valid` is high. The stimulus changes every input only on the falling clock edge and drives only defined values. It sweeps all four width codes and both modes with predicate registers that are random, all zeros or set only in their unused upper bits. Register 0 is loaded with zeros while the selector is 0. `out_ready` is toggled at random so that held outputs and back-to-back transfers both occur.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic [1:0] {
    EW_BYTE  = 2'b00,
    EW_HALF  = 2'b01,
    EW_WORD  = 2'b10,
    EW_DWORD = 2'b11
  } ewidth_e;
endpackage

// File: rtl/vmask_sel.sv
module vmask_sel #(
  parameter int MASK_W   = 64,
  parameter int NUM_MREG = 8,
  localparam int SEL_W   = $clog2(NUM_MREG)
) (
  input  logic [SEL_W-1:0]           msel,
  input  logic [NUM_MREG*MASK_W-1:0] bank,
  output logic [MASK_W-1:0]          lane_mask
);
  logic [MASK_W-1:0] regs [NUM_MREG];

  for (genvar k = 0; k < NUM_MREG; k++) begin : g_split
    assign regs[k] = bank[k*MASK_W +: MASK_W];
  end

  // Selector 0 encodes "unpredicated"; register 0 is never read here.
  always_comb begin
    if (msel == '0) lane_mask = '1;
    else            lane_mask = regs[msel];
  end
endmodule

// File: rtl/vmask_expand.sv
module vmask_expand
  import vmask_pkg::*;
#(
  parameter int VEC_W   = 512,
  localparam int NBYTES = VEC_W / 8
) (
  input  logic [NBYTES-1:0] lane_mask,
  input  logic [1:0]        ewidth,
  output logic [NBYTES-1:0] byte_en
);
  ewidth_e ew;
  assign ew = ewidth_e'(ewidth);

  // Byte b belongs to lane b >> log2(lane bytes); upper mask bits are never indexed.
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_comb begin
      unique case (ew)
        EW_BYTE:  byte_en[b] = lane_mask[b];
        EW_HALF:  byte_en[b] = lane_mask[b/2];
        EW_WORD:  byte_en[b] = lane_mask[b/4];
        default:  byte_en[b] = lane_mask[b/8];
      endcase
    end
  end
endmodule

// File: rtl/vmask_blend.sv
module vmask_blend #(
  parameter int VEC_W   = 512,
  localparam int NBYTES = VEC_W / 8
) (
  input  logic [VEC_W-1:0]  result,
  input  logic [VEC_W-1:0]  old_dst,
  input  logic [NBYTES-1:0] byte_en,
  input  logic              zero_mode,
  output logic [VEC_W-1:0]  blended
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_comb begin
      if (byte_en[b])     blended[b*8 +: 8] = result[b*8 +: 8];
      else if (zero_mode) blended[b*8 +: 8] = 8'h00;
      else                blended[b*8 +: 8] = old_dst[b*8 +: 8];
    end
  end
endmodule

// File: rtl/vmask_writer.sv
module vmask_writer #(
  parameter int VEC_W    = 512,
  parameter int NUM_MREG = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [VEC_W-1:0]                 result,
  input  logic [VEC_W-1:0]                 old_dst,
  input  logic [$clog2(NUM_MREG)-1:0]      msel,
  input  logic [NUM_MREG*(VEC_W/8)-1:0]    mreg_bank,
  input  logic [1:0]                       ewidth,
  input  logic                             zero_mode,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [VEC_W-1:0]                 out_data
);
  localparam int MASK_W = VEC_W / 8;

  logic [MASK_W-1:0] lane_mask;
  logic [MASK_W-1:0] byte_en;
  logic [VEC_W-1:0]  blended;
  logic              accept;

  vmask_sel #(.MASK_W(MASK_W), .NUM_MREG(NUM_MREG)) u_sel (
    .msel(msel), .bank(mreg_bank), .lane_mask(lane_mask)
  );

  vmask_expand #(.VEC_W(VEC_W)) u_exp (
    .lane_mask(lane_mask), .ewidth(ewidth), .byte_en(byte_en)
  );

  vmask_blend #(.VEC_W(VEC_W)) u_bl (
    .result(result), .old_dst(old_dst), .byte_en(byte_en),
    .zero_mode(zero_mode), .blended(blended)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= blended;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R12
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R12
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R11
  accept_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R2
  unpredicated_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && msel == '0) |=> (out_data == $past(result)));

  // R4
  zero_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && msel != '0 && zero_mode &&
     mreg_bank[32'(msel)*MASK_W +: MASK_W] == '0) |=> (out_data == '0));

  // R5
  merge_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && msel != '0 && !zero_mode &&
     mreg_bank[32'(msel)*MASK_W +: MASK_W] == '0) |=> (out_data == $past(old_dst)));
endmodule

// File: tb/vmask_writer_test.sv
module vmask_writer_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, out_valid, out_ready, zero_mode;
  logic [511:0] result, old_dst, out_data, mreg_bank;
  logic [2:0]   msel;
  logic [1:0]   ewidth;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string cur_req = "R13";

  logic         m_valid;
  logic [511:0] m_data;

  always #5 clk = ~clk;

  vmask_writer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .result(result), .old_dst(old_dst), .msel(msel), .mreg_bank(mreg_bank),
    .ewidth(ewidth), .zero_mode(zero_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [511:0] expect_vec(logic [511:0] r, logic [511:0] o,
      logic [2:0] s, logic [511:0] bank, logic [1:0] ew, logic zm);
    logic [63:0]  pm;
    logic [511:0] v;
    int lane_bits;
    int nlanes;
    pm = (s == 0) ? {64{1'b1}} : bank[s*64 +: 64];
    lane_bits = 8 << ew;
    nlanes = 512 / lane_bits;
    for (int i = 0; i < nlanes; i++) begin
      for (int j = 0; j < lane_bits; j++) begin
        if (pm[i])   v[i*lane_bits + j] = r[i*lane_bits + j];
        else if (zm) v[i*lane_bits + j] = 1'b0;
        else         v[i*lane_bits + j] = o[i*lane_bits + j];
      end
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_valid <= 1'b0;
    else if (in_valid && (!m_valid || out_ready)) begin
      m_valid <= 1'b1;
      m_data  <= expect_vec(result, old_dst, msel, mreg_bank, ewidth, zero_mode);
    end else if (out_ready) m_valid <= 1'b0;
  end

  task automatic check_ports();
    checks++;
    if (out_valid !== m_valid) begin
      errors++;
      $display("FAIL %s out_valid actual %b expected %b", cur_req, out_valid, m_valid);
    end
    checks++;
    if (in_ready !== (!m_valid || out_ready)) begin
      errors++;
      $display("FAIL R12 in_ready actual %b expected %b", in_ready, !m_valid || out_ready);
    end
    if (m_valid) begin
      checks++;
      if (out_data !== m_data) begin
        errors++;
        $display("FAIL %s out_data actual %h expected %h", cur_req, out_data, m_data);
      end
    end
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // kind: 0 random bank, 1 selected register zero, 2 only unused upper bits set
  task automatic run_phase(string req, int n, int sel_mode, int ew_mode,
                           int zm_mode, int kind, bit stall);
    cur_req = req;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check_ports();
      in_valid  = ($urandom % 4) != 0;
      out_ready = stall ? (($urandom % 2) == 1) : 1'b1;
      result    = rnd512();
      old_dst   = rnd512();
      mreg_bank = rnd512();
      msel      = (sel_mode < 0) ? 3'($urandom % 8) : 3'(sel_mode);
      ewidth    = (ew_mode < 0) ? 2'($urandom % 4) : 2'(ew_mode);
      zero_mode = (zm_mode < 0) ? 1'($urandom % 2) : 1'(zm_mode);
      if (kind == 1) mreg_bank[msel*64 +: 64] = '0;
      if (kind == 2) mreg_bank[msel*64 +: 64] = ~(64'hFFFF_FFFF_FFFF_FFFF >> (64 - (64 >> ewidth)))
                                               & (ewidth == 0 ? 64'h0 : 64'hFFFF_FFFF_FFFF_FFFF);
      if (kind == 3) mreg_bank[63:0] = '0;
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; result = '0; old_dst = '0;
    mreg_bank = '0; msel = '0; ewidth = '0; zero_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R13";
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R13 out_valid/in_ready actual %b/%b expected 0/1", out_valid, in_ready);
    end
    run_phase("R2",  40,  0, -1, -1, 0, 0);
    run_phase("R3",  40,  0, -1, -1, 3, 1);
    run_phase("R1",  80, -1, -1, -1, 0, 0);
    run_phase("R4",  60, -1, -1,  1, 0, 0);
    run_phase("R4",  30,  5, -1,  1, 1, 0);
    run_phase("R5",  60, -1, -1,  0, 0, 0);
    run_phase("R5",  30,  2, -1,  0, 1, 0);
    run_phase("R6",  50, -1,  0, -1, 0, 0);
    run_phase("R7",  50, -1,  1, -1, 0, 0);
    run_phase("R8",  50, -1,  2, -1, 0, 0);
    run_phase("R9",  50, -1,  3, -1, 0, 0);
    run_phase("R10", 60, -1, -1, -1, 2, 0);
    run_phase("R11", 60, -1, -1, -1, 0, 0);
    run_phase("R12", 200, -1, -1, -1, 0, 1);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check_ports();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule